// File: doc/BRIEF.md
# Multi-Channel Test Pattern Generator and Checker

The block sits on the sample path of a set of antenna-carrier channels, each carrying 32-bit words. A 2-bit mode input, shared by every channel, selects what it does. In the data modes the transmit words pass through unchanged. In the pattern modes the block replaces each transmit word with a generated test word. On the receive side it regenerates the same sequence and compares it with the incoming words.

Two pattern kinds are provided. The first is an 8-bit counter aligned to the radio frame. The second is an inverted pseudo-random sequence with a period of 2^23 - 1. In both kinds the 16-bit pattern value is written into both halves of the word. Each channel steps its own transmit and receive sequences on its own valid strobe. A frame-start pulse or a change of mode restarts every sequence. Each channel keeps a sticky mismatch flag, which stays set until it is cleared.

Top module: `test_pattern_unit`

## Requirements
- R1: With mode 00, each `tx_data_o` slice equals the matching `tx_data_i` slice in the same cycle, and no `err_o` bit is set, whatever `rx_data_i` carries.
- R2: Mode 11 behaves exactly like mode 00: transmit data passes through and no receive comparison takes place.
- R3: With mode 01, every transmit word is {8'h00, c, 8'h00, c}, where c is the channel's 8-bit count. In the cycle that carries `frame_start_i`, c is 0. The count advances by one after each cycle in which that channel's `tx_valid_i` is high.
- R4: The mode-01 count wraps from 255 to 0. The word produced after 256 valid words counted from frame start is all zero.
- R5: With mode 10, each half of the word is the bitwise inverse of 16 successive output bits of a Fibonacci LFSR with feedback x^23 + x^18 + 1. Each step outputs bit 22, then shifts left and inserts bit22 XOR bit17; the first bit goes to half bit 15. The register is seeded with all ones at frame start and advances 16 steps per valid word. The first word after frame start is 32'h0000_0000.
- R6: Each channel's sequence advances only on that channel's own valid strobe. Channels with different valid patterns therefore hold different sequence positions.
- R7: In mode 01 or 10, if `rx_valid_i[c]` is high and `rx_data_i` for channel c differs from that channel's expected receive word, `err_o[c]` is high from the next cycle on. The receive sequence follows the same rules as the transmit sequence, stepped by `rx_valid_i`.
- R8: A set `err_o` bit stays set until `err_clr_i` is high with no new mismatch on that channel in the same cycle. A mismatch in the clearing cycle keeps the bit set.
- R9: A change of `mode_i` restarts the transmit and receive sequences of every channel in the first cycle the new mode is present, just as frame start does. The `err_o` bits are left unchanged.
- R10: A mismatch on one channel sets only that channel's `err_o` bit.
- R11: While `rst_ni` is low, every `err_o` bit is 0 and every sequence returns to its seeded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 data, 01 counter, 10 inverted PRBS, 11 data |
| frame_start_i | input | 1 | Radio-frame start pulse; restarts all sequences |
| err_clr_i | input | 1 | Clears the sticky error flags |
| tx_valid_i | input | NUM_CH | Per-channel transmit word strobe |
| tx_data_i | input | NUM_CH*32 | Transmit sample words, channel 0 in the low bits |
| tx_data_o | output | NUM_CH*32 | Transmit words after pattern substitution |
| rx_valid_i | input | NUM_CH | Per-channel receive word strobe |
| rx_data_i | input | NUM_CH*32 | Receive words to check |
| err_o | output | NUM_CH | Sticky per-channel mismatch flags |

## Verification
The bench builds the block with NUM_CH = 3 and the default 8-bit count. Three channels are enough to drive different valid patterns side by side, and to corrupt one channel while its neighbours stay clean, which exposes cross-channel leakage of sequence state or error flags. With the 8-bit count the wrap from 255 to 0 comes after 256 valid words, so a directed run reaches it inside a short frame. Long mixed runs with random mode changes, frame starts and clears then exercise the restart and sticky-flag priorities against the reference model.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    MODE_DATA = 2'b00,
    MODE_CNT  = 2'b01,
    MODE_PRBS = 2'b10,
    MODE_RSVD = 2'b11
  } tpg_mode_e;

  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PRBS_W = 23;
  localparam int TAP_A  = 22;   // x^23
  localparam int TAP_B  = 17;   // x^18
  localparam logic [PRBS_W-1:0] PRBS_SEED = '1;

  // 16 output bits, first bit in the MSB
  function automatic logic [HALF_W-1:0] prbs_chunk(input logic [PRBS_W-1:0] s);
    logic [PRBS_W-1:0] st;
    logic [HALF_W-1:0] o;
    st = s;
    o  = '0;
    for (int k = 0; k < HALF_W; k++) begin
      o[HALF_W-1-k] = st[TAP_A];
      st = {st[PRBS_W-2:0], st[TAP_A] ^ st[TAP_B]};
    end
    return o;
  endfunction

  function automatic logic [PRBS_W-1:0] prbs_adv(input logic [PRBS_W-1:0] s);
    logic [PRBS_W-1:0] st;
    st = s;
    for (int k = 0; k < HALF_W; k++) begin
      st = {st[PRBS_W-2:0], st[TAP_A] ^ st[TAP_B]};
    end
    return st;
  endfunction

endpackage

// File: rtl/tpg_seq.sv
module tpg_seq
  import tpg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              restart_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] word_o
);

  logic [CNT_W-1:0]  cnt_q, cnt_cur;
  logic [PRBS_W-1:0] sr_q, sr_cur;
  logic [HALF_W-1:0] half;

  always_comb begin
    cnt_cur = restart_i ? '0 : cnt_q;
    sr_cur  = restart_i ? PRBS_SEED : sr_q;
    if (mode_i == MODE_CNT) half = {{(HALF_W-CNT_W){1'b0}}, cnt_cur};
    else                    half = ~prbs_chunk(sr_cur);
    word_o = {half, half};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= PRBS_SEED;
    end else if (adv_i) begin
      cnt_q <= cnt_cur + 1'b1;
      sr_q  <= prbs_adv(sr_cur);
    end else begin
      cnt_q <= cnt_cur;
      sr_q  <= sr_cur;
    end
  end

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk
  import tpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              check_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [WORD_W-1:0] exp_word_i,
  input  logic              clr_i,
  output logic              err_o
);

  logic mismatch;
  assign mismatch = check_i && (rx_word_i != exp_word_i);

  // new mismatch wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (mismatch) err_o <= 1'b1;
    else if (clr_i)    err_o <= 1'b0;
  end

endmodule

// File: rtl/test_pattern_unit.sv
module test_pattern_unit
  import tpg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic                     frame_start_i,
  input  logic                     err_clr_i,
  input  logic [NUM_CH-1:0]        tx_valid_i,
  input  logic [NUM_CH*WORD_W-1:0] tx_data_i,
  output logic [NUM_CH*WORD_W-1:0] tx_data_o,
  input  logic [NUM_CH-1:0]        rx_valid_i,
  input  logic [NUM_CH*WORD_W-1:0] rx_data_i,
  output logic [NUM_CH-1:0]        err_o
);

  logic [1:0] mode_q;
  logic       restart;
  logic       pat_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_DATA;
    else         mode_q <= mode_i;
  end

  assign restart = frame_start_i || (mode_i != mode_q);
  assign pat_on  = (mode_i == MODE_CNT) || (mode_i == MODE_PRBS);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [WORD_W-1:0] tx_pat, rx_exp;

    tpg_seq #(.CNT_W(CNT_W)) u_tx_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode_i),
      .restart_i(restart),
      .adv_i    (pat_on && tx_valid_i[ch]),
      .word_o   (tx_pat)
    );

    tpg_seq #(.CNT_W(CNT_W)) u_rx_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode_i),
      .restart_i(restart),
      .adv_i    (pat_on && rx_valid_i[ch]),
      .word_o   (rx_exp)
    );

    tpg_chk u_chk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .check_i   (pat_on && rx_valid_i[ch]),
      .rx_word_i (rx_data_i[ch*WORD_W +: WORD_W]),
      .exp_word_i(rx_exp),
      .clr_i     (err_clr_i),
      .err_o     (err_o[ch])
    );

    assign tx_data_o[ch*WORD_W +: WORD_W] = pat_on ? tx_pat : tx_data_i[ch*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/tpg_sva.sv
module tpg_sva
  import tpg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               mode_i,
  input logic                     frame_start_i,
  input logic                     err_clr_i,
  input logic [NUM_CH*WORD_W-1:0] tx_data_i,
  input logic [NUM_CH*WORD_W-1:0] tx_data_o,
  input logic [NUM_CH-1:0]        err_o
);

  logic              active;
  logic [NUM_CH-1:0] halves_eq, hi_zero;

  assign active = (mode_i == MODE_CNT) || (mode_i == MODE_PRBS);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_c
    logic [WORD_W-1:0] w;
    assign w = tx_data_o[ch*WORD_W +: WORD_W];
    assign halves_eq[ch] = (w[WORD_W-1:HALF_W] == w[HALF_W-1:0]);
    assign hi_zero[ch]   = (w[HALF_W-1:CNT_W] == '0) && (w[WORD_W-1:HALF_W+CNT_W] == '0);
  end

  AST_PASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (tx_data_o == tx_data_i)); // R1
  AST_NO_ERR_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> ((err_o & ~$past(err_o)) == '0)); // R2
  AST_HALVES_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (&halves_eq)); // R5
  AST_CNT_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CNT) |-> (&hi_zero)); // R3
  AST_FRAME_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CNT && frame_start_i) |-> (tx_data_o == '0)); // R3
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_i |=> ((err_o & $past(err_o)) == $past(err_o))); // R8

endmodule

bind test_pattern_unit tpg_sva #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .frame_start_i(frame_start_i),
  .err_clr_i    (err_clr_i),
  .tx_data_i    (tx_data_i),
  .tx_data_o    (tx_data_o),
  .err_o        (err_o)
);

// File: tb/tb_test_pattern_unit.sv
`timescale 1ns/1ps
module tb_test_pattern_unit;

  localparam int NCH = 3;
  localparam int W   = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic             frame_start_i = 1'b0;
  logic             err_clr_i = 1'b0;
  logic [NCH-1:0]   tx_valid_i = '0;
  logic [NCH*W-1:0] tx_data_i = '0;
  logic [NCH*W-1:0] tx_data_o;
  logic [NCH-1:0]   rx_valid_i = '0;
  logic [NCH*W-1:0] rx_data_i = '0;
  logic [NCH-1:0]   err_o;

  always #2.5 clk = ~clk;

  test_pattern_unit #(.NUM_CH(NCH), .CNT_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .frame_start_i(frame_start_i),
    .err_clr_i(err_clr_i), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_data_o(tx_data_o), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .err_o(err_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R11";
  bit    want_zero = 0;

  // reference model
  int           t_cnt[NCH];
  int           r_cnt[NCH];
  logic [22:0]  t_sr[NCH];
  logic [22:0]  r_sr[NCH];
  logic [NCH-1:0] m_err;
  logic [1:0]   m_mode_q;

  function automatic logic [31:0] ref_word(input logic [1:0] md, input int c, input logic [22:0] s);
    logic [15:0] h;
    logic [22:0] x;
    if (md == 2'b01) begin
      h = {8'h00, 8'(c)};
    end else begin
      x = s;
      for (int k = 0; k < 16; k++) begin
        h[15-k] = ~x[22];
        x = {x[21:0], x[22] ^ x[17]};
      end
    end
    return {h, h};
  endfunction

  function automatic logic [22:0] ref_step(input logic [22:0] s);
    logic [22:0] x;
    x = s;
    for (int k = 0; k < 16; k++) x = {x[21:0], x[22] ^ x[17]};
    return x;
  endfunction

  task automatic check(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      t_cnt[c] = 0; r_cnt[c] = 0; t_sr[c] = '1; r_sr[c] = '1;
    end
    m_err = '0;
    m_mode_q = 2'b00;
  endtask

  task automatic cycle(input logic [1:0] md, input logic fs, input logic [NCH-1:0] tv,
                       input logic [NCH-1:0] rv, input logic [NCH-1:0] bad, input logic clr);
    bit restart, act;
    logic [31:0] tx_exp[NCH];
    logic [31:0] rx_exp[NCH];
    int          tc[NCH], rc[NCH];
    logic [22:0] ts[NCH], rs[NCH];
    logic [NCH*W-1:0] din;
    @(negedge clk);
    restart = fs || (md != m_mode_q);
    act = (md == 2'b01) || (md == 2'b10);
    for (int c = 0; c < NCH; c++) begin
      tc[c] = restart ? 0 : t_cnt[c];
      ts[c] = restart ? 23'h7fffff : t_sr[c];
      rc[c] = restart ? 0 : r_cnt[c];
      rs[c] = restart ? 23'h7fffff : r_sr[c];
      rx_exp[c] = ref_word(md, rc[c], rs[c]);
      din[c*W +: W] = $urandom;
    end
    mode_i = md; frame_start_i = fs; tx_valid_i = tv; rx_valid_i = rv; err_clr_i = clr;
    tx_data_i = din;
    for (int c = 0; c < NCH; c++) begin
      tx_exp[c] = act ? ref_word(md, tc[c], ts[c]) : din[c*W +: W];
      if (act) rx_data_i[c*W +: W] = bad[c] ? (rx_exp[c] ^ (32'h1 << ($urandom % 32))) : rx_exp[c];
      else     rx_data_i[c*W +: W] = $urandom;
    end
    #1;
    for (int c = 0; c < NCH; c++)
      check(tag, $sformatf("tx ch%0d", c), tx_data_o[c*W +: W], tx_exp[c]);
    check(tag, "err_o", 32'(err_o), 32'(m_err));
    if (want_zero) check(tag, "directed zero word ch0", tx_data_o[W-1:0], 32'h0);
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (act && tv[c]) begin t_cnt[c] = (tc[c] + 1) % 256; t_sr[c] = ref_step(ts[c]); end
      else              begin t_cnt[c] = tc[c];             t_sr[c] = ts[c]; end
      if (act && rv[c]) begin r_cnt[c] = (rc[c] + 1) % 256; r_sr[c] = ref_step(rs[c]); end
      else              begin r_cnt[c] = rc[c];             r_sr[c] = rs[c]; end
      if (act && rv[c] && bad[c]) m_err[c] = 1'b1;
      else if (clr)               m_err[c] = 1'b0;
    end
    m_mode_q = md;
  endtask

  initial begin
    #(5ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "err_o in reset", 32'(err_o), 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    tag = "R1";
    for (int i = 0; i < 30; i++) cycle(2'b00, i % 7 == 0, 3'($urandom), 3'($urandom), 3'($urandom), 1'b0);
    tag = "R2";
    for (int i = 0; i < 30; i++) cycle(2'b11, i % 5 == 0, 3'($urandom), 3'($urandom), 3'($urandom), 1'b0);

    // R3/R6: counter mode with different valid patterns per channel
    tag = "R3";
    cycle(2'b01, 1'b1, 3'b111, 3'b111, 3'b000, 1'b0);
    tag = "R6";
    for (int i = 1; i < 256; i++) cycle(2'b01, 1'b0, {1'($urandom), 1'(i % 2), 1'b1}, 3'($urandom), 3'b000, 1'b0);
    // R4: 256 valid words on ch0 since frame start -> wrapped to 0
    tag = "R4"; want_zero = 1;
    cycle(2'b01, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);
    want_zero = 0;
    for (int i = 0; i < 20; i++) cycle(2'b01, 1'b0, 3'b111, 3'($urandom), 3'b000, 1'b0);

    // R5: PRBS mode, first word after frame start is zero
    tag = "R5"; want_zero = 1;
    cycle(2'b10, 1'b1, 3'b111, 3'b111, 3'b000, 1'b0);
    want_zero = 0;
    for (int i = 0; i < 100; i++) cycle(2'b10, 1'b0, 3'($urandom), 3'($urandom), 3'b000, 1'b0);

    // R7/R10: corrupt channel 1 only
    tag = "R7";
    cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b010, 1'b0);
    tag = "R10";
    for (int i = 0; i < 5; i++) cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);
    // R8: clear coinciding with a fresh mismatch keeps the bit
    tag = "R8";
    cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b010, 1'b1);
    cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);
    cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b000, 1'b1);
    cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);
    // invalid receive word is not compared
    cycle(2'b10, 1'b0, 3'b111, 3'b000, 3'b111, 1'b0);
    cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);

    // R9: mode change without frame start restarts sequences
    tag = "R9"; want_zero = 1;
    cycle(2'b01, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);
    want_zero = 0;
    for (int i = 0; i < 10; i++) cycle(2'b01, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);
    want_zero = 1;
    cycle(2'b10, 1'b0, 3'b101, 3'b111, 3'b001, 1'b0);
    want_zero = 0;
    for (int i = 0; i < 10; i++) cycle(2'b10, 1'b0, 3'b111, 3'b111, 3'b000, 1'b0);

    // mixed random run
    tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] md;
      md = ($urandom % 40 == 0) ? 2'($urandom) : m_mode_q;
      cycle(md, $urandom % 50 == 0, 3'($urandom), 3'($urandom),
            ($urandom % 30 == 0) ? 3'($urandom) : 3'b000, $urandom % 20 == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule